// File: doc/BRIEF.md
# SD Host Tuning Control Register and Read-Block Engine

This block holds the second host control register of an SD host controller. It also runs the read-block engine that uses that register's tuning bits. Software reaches the register over a simple register bus in two ways: with 16-bit accesses at its own offset, or with 32-bit accesses to the containing dword. The low half of that dword is the auto-CMD12 error status, which comes in from elsewhere as a read-only input.

A block read starts with a one-cycle start pulse. Bytes then arrive from the card side on a valid/ready stream, one byte per accepted beat. In a normal block each byte goes into the data buffer at its index, and completion signals that the buffer is ready to read. While the execute-tuning bit is set, the bytes are still consumed but nothing is written to the buffer. When such a tuning block completes, hardware clears execute-tuning, sets sampling-clock-select and drops the three present-state flags, all in one update. No buffer-ready event is raised for a tuning block. Every completion raises a one-cycle interrupt re-evaluation strobe.

Top module: `sdtune_ctrl`

## Requirements
- R1: Register fields: bits 2:0 UHS mode, bit 3 1.8 V enable, bits 5:4 driver strength, bit 6 execute-tuning, bit 7 sampling-clock-select, bit 14 async interrupt enable, bit 15 preset enable. Reset clears the register, all present-state flags and all pulses.
- R2: Bits 13:8 always read as zero and ignore writes.
- R3: A narrow (16-bit) access at offset 0x3E reads `{16'h0, reg}` and writes `wdata[15:0]`. A wide (32-bit) access at 0x3C reads `{reg, status}` and writes `wdata[31:16]` into the register. A narrow read at 0x3C returns `{16'h0, status}`, and any other read returns zero.
- R4: When idle and not blocked, a start pulse sets DAT-active, read-active and data-inhibit one cycle later. The block length in bytes is `blk_size[11:0]`. A start while a block is in progress is ignored.
- R5: A start with multi-block, count-enable and a zero block count all present has no effect.
- R6: `din_ready` is high only while bytes are being received. In a normal block, each accepted byte is written to the buffer with `buf_we`, at addresses 0, 1, 2 and so on in arrival order.
- R7: While execute-tuning is set, accepted bytes are consumed and `buf_we` stays low.
- R8: `blk_done` is a one-cycle pulse in the cycle after the last byte is accepted, or in the cycle after the start for a zero-length block. `irq_update` pulses in the same cycle.
- R9: On completion with execute-tuning set, the next cycle shows bit 6 cleared, bit 7 set and all three flags low, and `buf_rd_ready` does not pulse.
- R10: On a normal completion, `buf_rd_ready` pulses together with `blk_done`. DAT-active and read-active drop, and data-inhibit stays set until a `buf_drain` pulse arrives while the block is idle and no start is accepted.
- R11: When a software write lands in the completion cycle of a tuning block, hardware's values for bits 6 and 7 win, and the other bits take the written value.
- R12: Software writes to bits 6 and 7 take effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from address) |
| acmd_err_sts | input | 16 | Auto-CMD12 error status, read-only |
| blk_start | input | 1 | Block read request pulse |
| xfer_multi | input | 1 | Multi-block transfer mode |
| xfer_cnt_en | input | 1 | Block count enable |
| blk_count | input | 16 | Remaining block count |
| blk_size | input | 16 | Block size (low 12 bits used) |
| din_valid | input | 1 | Card byte valid |
| din_data | input | 8 | Card byte |
| din_ready | output | 1 | Byte accepted when valid |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 12 | Buffer byte index |
| buf_wdata | output | 8 | Buffer write byte |
| buf_drain | input | 1 | Buffer drained by host |
| dat_active | output | 1 | DAT line active flag |
| read_active | output | 1 | Read in progress flag |
| data_inhibit | output | 1 | Data inhibit flag |
| blk_done | output | 1 | Block completion pulse |
| buf_rd_ready | output | 1 | Buffer read ready pulse |
| irq_update | output | 1 | Interrupt re-evaluation pulse |
| hc2_value | output | 16 | Current register contents |

## Verification
A stuck or mistimed engine state shows at `din_ready` and `blk_done` within one cycle of the expected last byte. A lost tuning decision shows in three places. `buf_we` fires during discard, bit 6 or 7 reads wrong in the cycle after `blk_done`, or the flags stay high. A corrupted register bit shows on the very next read, because the bench keeps the register visible on `reg_rdata` every cycle. The priority between software and hardware can only be seen by placing a write exactly in the completion cycle, and the bench does that.

// File: rtl/sdtune_pkg.sv
package sdtune_pkg;
  localparam int HC2_W      = 16;
  localparam int BIT_TUNE   = 6;
  localparam int BIT_CLKSEL = 7;
  localparam logic [HC2_W-1:0] HC2_WMASK = 16'hC0FF;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DONE} blk_state_e;

  function automatic logic [HC2_W-1:0] hc2_clean(input logic [HC2_W-1:0] v);
    return v & HC2_WMASK;
  endfunction

  function automatic logic start_blocked(input logic multi, input logic cnt_en,
                                         input logic [15:0] cnt);
    return multi && cnt_en && (cnt == 16'd0);
  endfunction

  function automatic logic [HC2_W-1:0] hc2_after_tune(input logic [HC2_W-1:0] v);
    logic [HC2_W-1:0] r;
    r = v;
    r[BIT_TUNE]   = 1'b0;
    r[BIT_CLKSEL] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/sdtune_hc2_reg.sv
module sdtune_hc2_reg
  import sdtune_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [HC2_W-1:0] sw_data,
  input  logic             hw_tune_done,
  output logic [HC2_W-1:0] hc2_q
);
  logic [HC2_W-1:0] hc2_d;

  always_comb begin
    hc2_d = hc2_q;
    if (sw_we) hc2_d = hc2_clean(sw_data);
    if (hw_tune_done) hc2_d = hc2_after_tune(hc2_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hc2_q <= '0;
    else        hc2_q <= hc2_d;
  end
endmodule

// File: rtl/sdtune_bus_if.sv
module sdtune_bus_if
  import sdtune_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int OFF_HC2 = 'h3E
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wide,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic [HC2_W-1:0]  hc2_q,
  input  logic [15:0]       sts_in,
  output logic              sw_we,
  output logic [HC2_W-1:0]  sw_data,
  output logic [31:0]       reg_rdata
);
  localparam logic [ADDR_W-1:0] A_NARROW = ADDR_W'(OFF_HC2);
  localparam logic [ADDR_W-1:0] A_DWORD  = ADDR_W'(OFF_HC2 & ~3);

  logic hit_narrow, hit_wide, hit_sts;

  assign hit_narrow = !reg_wide && (reg_addr == A_NARROW);
  assign hit_wide   =  reg_wide && (reg_addr == A_DWORD);
  assign hit_sts    = !reg_wide && (reg_addr == A_DWORD);

  assign sw_we   = reg_wr && (hit_narrow || hit_wide);
  assign sw_data = hit_wide ? reg_wdata[31:16] : reg_wdata[15:0];

  always_comb begin
    reg_rdata = '0;
    if (hit_narrow)    reg_rdata = {16'h0, hc2_q};
    else if (hit_wide) reg_rdata = {hc2_q, sts_in};
    else if (hit_sts)  reg_rdata = {16'h0, sts_in};
  end
endmodule

// File: rtl/sdtune_blk_engine.sv
module sdtune_blk_engine
  import sdtune_pkg::*;
#(
  parameter int SIZE_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              xfer_multi,
  input  logic              xfer_cnt_en,
  input  logic [15:0]       blk_count,
  input  logic [15:0]       blk_size,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  input  logic              tune,
  input  logic              buf_drain,
  output logic              din_ready,
  output logic              buf_we,
  output logic [SIZE_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              dat_active,
  output logic              read_active,
  output logic              data_inhibit,
  output logic              blk_done,
  output logic              buf_rd_ready,
  output logic              irq_update,
  output logic              tune_done
);
  blk_state_e        state_q;
  logic [SIZE_W-1:0] cnt_q, size_q, size_in;
  logic              accept, last_byte, go;

  assign size_in   = blk_size[SIZE_W-1:0];
  assign go        = blk_start && !start_blocked(xfer_multi, xfer_cnt_en, blk_count);
  assign din_ready = (state_q == ST_RECV);
  assign accept    = din_ready && din_valid;
  assign last_byte = (cnt_q == size_q - SIZE_W'(1));

  assign buf_we       = accept && !tune;
  assign buf_addr     = cnt_q;
  assign buf_wdata    = din_data;
  assign blk_done     = (state_q == ST_DONE);
  assign irq_update   = blk_done;
  assign buf_rd_ready = blk_done && !tune;
  assign tune_done    = blk_done && tune;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      size_q       <= '0;
      dat_active   <= 1'b0;
      read_active  <= 1'b0;
      data_inhibit <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            dat_active   <= 1'b1;
            read_active  <= 1'b1;
            data_inhibit <= 1'b1;
            cnt_q        <= '0;
            size_q       <= size_in;
            state_q      <= (size_in == '0) ? ST_DONE : ST_RECV;
          end else if (buf_drain) begin
            data_inhibit <= 1'b0;
          end
        end
        ST_RECV: begin
          if (accept) begin
            cnt_q <= cnt_q + SIZE_W'(1);
            if (last_byte) state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          state_q     <= ST_IDLE;
          dat_active  <= 1'b0;
          read_active <= 1'b0;
          if (tune) data_inhibit <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdtune_ctrl.sv
module sdtune_ctrl
  import sdtune_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wide,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [15:0]       acmd_err_sts,
  input  logic              blk_start,
  input  logic              xfer_multi,
  input  logic              xfer_cnt_en,
  input  logic [15:0]       blk_count,
  input  logic [15:0]       blk_size,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  output logic              din_ready,
  output logic              buf_we,
  output logic [SIZE_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  input  logic              buf_drain,
  output logic              dat_active,
  output logic              read_active,
  output logic              data_inhibit,
  output logic              blk_done,
  output logic              buf_rd_ready,
  output logic              irq_update,
  output logic [HC2_W-1:0]  hc2_value
);
  logic             sw_we;
  logic [HC2_W-1:0] sw_data;
  logic             tune_done;

  sdtune_bus_if #(.ADDR_W(ADDR_W)) bus_i (
    .reg_addr (reg_addr),
    .reg_wide (reg_wide),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .hc2_q    (hc2_value),
    .sts_in   (acmd_err_sts),
    .sw_we    (sw_we),
    .sw_data  (sw_data),
    .reg_rdata(reg_rdata)
  );

  sdtune_hc2_reg reg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (sw_we),
    .sw_data     (sw_data),
    .hw_tune_done(tune_done),
    .hc2_q       (hc2_value)
  );

  sdtune_blk_engine #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) eng_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start   (blk_start),
    .xfer_multi  (xfer_multi),
    .xfer_cnt_en (xfer_cnt_en),
    .blk_count   (blk_count),
    .blk_size    (blk_size),
    .din_valid   (din_valid),
    .din_data    (din_data),
    .tune        (hc2_value[BIT_TUNE]),
    .buf_drain   (buf_drain),
    .din_ready   (din_ready),
    .buf_we      (buf_we),
    .buf_addr    (buf_addr),
    .buf_wdata   (buf_wdata),
    .dat_active  (dat_active),
    .read_active (read_active),
    .data_inhibit(data_inhibit),
    .blk_done    (blk_done),
    .buf_rd_ready(buf_rd_ready),
    .irq_update  (irq_update),
    .tune_done   (tune_done)
  );
endmodule

// File: rtl/sdtune_ctrl_chk.sv
module sdtune_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  reg_addr,
  input logic        reg_wide,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        blk_start,
  input logic        xfer_multi,
  input logic        xfer_cnt_en,
  input logic [15:0] blk_count,
  input logic        din_valid,
  input logic        din_ready,
  input logic        buf_we,
  input logic        dat_active,
  input logic        read_active,
  input logic        data_inhibit,
  input logic        blk_done,
  input logic        buf_rd_ready,
  input logic        irq_update,
  input logic [15:0] hc2_value
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hc2_value[13:8] == 6'h0);

  a_r5_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !read_active && xfer_multi && xfer_cnt_en && blk_count == 16'h0)
    |=> !read_active);

  a_r6_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> (read_active && dat_active && !blk_done));

  a_r7_no_write_in_tuning: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (din_valid && din_ready && !hc2_value[6]));

  a_r8_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_update == blk_done);

  a_r9_tune_completion: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && hc2_value[6]) |=>
    (!hc2_value[6] && hc2_value[7] && !dat_active && !read_active && !data_inhibit));

  a_r9_no_ready_in_tuning: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && hc2_value[6]) |-> !buf_rd_ready);

  a_r10_normal_completion: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && !hc2_value[6]) |=> (!dat_active && !read_active && data_inhibit));

  a_r12_sw_write_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wide && reg_addr == 8'h3E && !blk_done) |=>
    hc2_value == ($past(reg_wdata[15:0]) & 16'hC0FF));
endmodule

bind sdtune_ctrl sdtune_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_addr    (reg_addr),
  .reg_wide    (reg_wide),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .blk_start   (blk_start),
  .xfer_multi  (xfer_multi),
  .xfer_cnt_en (xfer_cnt_en),
  .blk_count   (blk_count),
  .din_valid   (din_valid),
  .din_ready   (din_ready),
  .buf_we      (buf_we),
  .dat_active  (dat_active),
  .read_active (read_active),
  .data_inhibit(data_inhibit),
  .blk_done    (blk_done),
  .buf_rd_ready(buf_rd_ready),
  .irq_update  (irq_update),
  .hc2_value   (hc2_value)
);

// File: tb/sdtune_ctrl_tb_top.sv
module sdtune_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wide, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] acmd_err_sts;
  logic        blk_start, xfer_multi, xfer_cnt_en;
  logic [15:0] blk_count, blk_size;
  logic        din_valid;
  logic [7:0]  din_data;
  logic        din_ready, buf_we;
  logic [11:0] buf_addr;
  logic [7:0]  buf_wdata;
  logic        buf_drain;
  logic        dat_active, read_active, data_inhibit;
  logic        blk_done, buf_rd_ready, irq_update;
  logic [15:0] hc2_value;

  always #5 clk = ~clk;

  sdtune_ctrl dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int       m_state;   // 0 idle, 1 receiving, 2 done
  int       m_cnt, m_size;
  bit [15:0] m_hc2;
  bit       m_dat, m_rd, m_inh;
  int       wr_seen, rdy_seen;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] exp_rdata(input bit [7:0] a, input bit w,
                                          input bit [15:0] r, input bit [15:0] s);
    if (!w && a == 8'h3E) return {16'h0, r};
    if (w && a == 8'h3C)  return {r, s};
    if (!w && a == 8'h3C) return {16'h0, s};
    return 32'h0;
  endfunction

  task automatic cyc();
    bit        tune, e_we;
    int        n_state, n_cnt, n_size;
    bit [15:0] n_hc2;
    bit        n_dat, n_rd, n_inh;
    #4;
    tune = m_hc2[6];
    e_we = (m_state == 1) && din_valid && !tune;
    if (rst_n) begin
      chk("R1 hc2_value", hc2_value, m_hc2);
      chk("R3 reg_rdata", reg_rdata, exp_rdata(reg_addr, reg_wide, m_hc2, acmd_err_sts));
      chk("R6 din_ready", din_ready, m_state == 1);
      chk("R7 buf_we", buf_we, e_we);
      if (e_we) begin
        chk("R6 buf_addr", buf_addr, m_cnt);
        chk("R6 buf_wdata", buf_wdata, din_data);
      end
      chk("R4 flags", {dat_active, read_active, data_inhibit}, {m_dat, m_rd, m_inh});
      chk("R8 blk_done", blk_done, m_state == 2);
      chk("R8 irq_update", irq_update, m_state == 2);
      chk("R10 buf_rd_ready", buf_rd_ready, (m_state == 2) && !tune);
      if (buf_we) wr_seen++;
      if (buf_rd_ready) rdy_seen++;
    end
    n_state = m_state; n_cnt = m_cnt; n_size = m_size;
    n_hc2 = m_hc2; n_dat = m_dat; n_rd = m_rd; n_inh = m_inh;
    if (reg_wr && !reg_wide && reg_addr == 8'h3E) n_hc2 = reg_wdata[15:0] & 16'hC0FF;
    if (reg_wr && reg_wide && reg_addr == 8'h3C)  n_hc2 = reg_wdata[31:16] & 16'hC0FF;
    if (m_state == 0) begin
      if (blk_start && !(xfer_multi && xfer_cnt_en && blk_count == 0)) begin
        n_dat = 1; n_rd = 1; n_inh = 1; n_cnt = 0;
        n_size = blk_size % 4096;
        n_state = (n_size == 0) ? 2 : 1;
      end else if (buf_drain) n_inh = 0;
    end else if (m_state == 1) begin
      if (din_valid) begin
        n_cnt = m_cnt + 1;
        if (m_cnt + 1 == m_size) n_state = 2;
      end
    end else begin
      n_state = 0; n_dat = 0; n_rd = 0;
      if (tune) begin
        n_inh = 0;
        n_hc2[6] = 0;
        n_hc2[7] = 1;
      end
    end
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_size = 0; m_hc2 = 0; m_dat = 0; m_rd = 0; m_inh = 0;
    end else begin
      m_state = n_state; m_cnt = n_cnt; m_size = n_size;
      m_hc2 = n_hc2; m_dat = n_dat; m_rd = n_rd; m_inh = n_inh;
    end
    @(negedge clk);
  endtask

  task automatic wr16(input bit [15:0] d);
    reg_addr = 8'h3E; reg_wide = 0; reg_wr = 1; reg_wdata = {16'hDEAD, d};
    cyc();
    reg_wr = 0;
  endtask

  task automatic start(input bit [15:0] size, input bit multi, input bit cen, input bit [15:0] cnt);
    blk_size = size; xfer_multi = multi; xfer_cnt_en = cen; blk_count = cnt; blk_start = 1;
    cyc();
    blk_start = 0;
  endtask

  // runs until idle; optional software write in the completion cycle
  task automatic run_block(input bit sw_at_done, input bit [15:0] sw_val, input bit extra_start);
    int k = 0;
    while (m_state != 0) begin
      din_valid = (k % 3) != 1;
      din_data  = 8'h40 + 8'(k * 7);
      reg_wr = 0;
      blk_start = 0;
      if (sw_at_done && m_state == 2) begin
        reg_addr = 8'h3E; reg_wide = 0; reg_wr = 1; reg_wdata = {16'h0, sw_val};
      end
      if (extra_start && k == 2) begin
        blk_start = 1; blk_size = 16'd10;
      end
      cyc();
      k++;
    end
    din_valid = 0; reg_wr = 0; blk_start = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_addr = 8'h3E; reg_wide = 0; reg_wr = 0; reg_wdata = 0;
    acmd_err_sts = 16'hA5C3; blk_start = 0; xfer_multi = 0; xfer_cnt_en = 0;
    blk_count = 0; blk_size = 0; din_valid = 0; din_data = 0; buf_drain = 0;
    m_state = 0; m_cnt = 0; m_size = 0; m_hc2 = 0; m_dat = 0; m_rd = 0; m_inh = 0;
    wr_seen = 0; rdy_seen = 0;
    @(negedge clk);
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 reset value", hc2_value, 16'h0000);

    // R2: reserved bits
    wr16(16'hFFFF);
    cyc();
    chk("R2 reserved bits read zero", hc2_value, 16'hC0FF);
    wr16(16'h0000);

    // R3: dword access
    reg_addr = 8'h3C; reg_wide = 1; reg_wr = 1; reg_wdata = 32'h8035_1234;
    cyc();
    reg_wr = 0;
    cyc();
    chk("R3 wide read", reg_rdata, 32'h8035_A5C3);
    reg_wide = 0; cyc();
    chk("R3 narrow status read", reg_rdata, 32'h0000_A5C3);
    reg_addr = 8'h10; cyc();
    chk("R3 other offset", reg_rdata, 32'h0);
    reg_addr = 8'h3E;
    wr16(16'h0000);

    // R6 R10: normal block of 5 bytes
    wr_seen = 0; rdy_seen = 0;
    start(16'd5, 0, 0, 0);
    run_block(0, 0, 0);
    chk("R6 bytes written", wr_seen, 5);
    chk("R10 ready pulses", rdy_seen, 1);
    chk("R10 inhibit held", data_inhibit, 1'b1);
    buf_drain = 1; cyc(); buf_drain = 0; cyc();
    chk("R10 inhibit after drain", data_inhibit, 1'b0);

    // R4: start while busy ignored
    wr_seen = 0;
    start(16'd3, 0, 0, 0);
    run_block(0, 0, 1);
    chk("R4 busy start ignored", wr_seen, 3);
    buf_drain = 1; cyc(); buf_drain = 0;

    // R5: blocked start
    start(16'd4, 1, 1, 16'd0);
    cyc();
    chk("R5 blocked start", {read_active, din_ready}, 2'b00);
    start(16'd2, 1, 1, 16'd2);
    run_block(0, 0, 0);
    buf_drain = 1; cyc(); buf_drain = 0;

    // R4: size masked to 12 bits
    wr_seen = 0;
    start(16'hF003, 0, 0, 0);
    run_block(0, 0, 0);
    chk("R4 size masked", wr_seen, 3);
    buf_drain = 1; cyc(); buf_drain = 0;

    // R12 R7 R9: tuning block
    wr16(16'h0042);
    chk("R12 tune bit set", hc2_value, 16'h0042);
    wr_seen = 0; rdy_seen = 0;
    start(16'd64, 0, 0, 0);
    run_block(0, 0, 0);
    chk("R7 no buffer writes", wr_seen, 0);
    chk("R9 register after tuning", hc2_value, 16'h0082);
    chk("R9 flags released", {dat_active, read_active, data_inhibit}, 3'b000);
    chk("R9 no ready pulse", rdy_seen, 0);

    // R11: software write in completion cycle
    wr16(16'h0043);
    start(16'd2, 0, 0, 0);
    run_block(1, 16'h4045, 0);
    cyc();
    chk("R11 hardware wins", hc2_value, 16'h4085);

    // R8: zero-length normal block
    wr16(16'h0000);
    chk("R12 bits cleared by software", hc2_value, 16'h0000);
    blk_size = 0; blk_start = 1; xfer_multi = 0; xfer_cnt_en = 0;
    cyc();
    blk_start = 0;
    chk("R8 zero-length done", blk_done, 1'b1);
    cyc();
    chk("R8 done pulse ends", blk_done, 1'b0);
    buf_drain = 1; cyc(); buf_drain = 0;
    repeat (3) cyc();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule